// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a first-in, first-out buffer that holds up to 1024 words of 18 bits. A producer and a consumer work on two free-running clocks that have no fixed relation to each other. The producer writes a word on a write-clock edge when the block signals it can accept data and both of the producer's write enables are high. The read side does not wait to be asked for the first word. That word moves into a registered output on its own, and an output-ready flag then marks it as valid. Each later word is taken when the consumer has both read enables and the output enable high.

Write and read positions cross between the clock domains as Gray-coded pointers, each through a two-stage synchronizer. Those stages, together with the per-domain reset synchronizers, set the fixed latencies of the flags. A half-full flag and an almost-full/almost-empty flag report how full the buffer is. The margin used by the second flag can be programmed. It is captured from the low nine data inputs when the define input falls. It takes effect at a reset that is given while the define input is held low. Otherwise the margin is 128.

Top module: `dcf_top`

## Requirements
- R1: A word is stored on a rising `wrClk` edge only when `inReady`, `wrEn1` and `wrEn2` are all high. An attempt with any of them low stores nothing.
- R2: After the first word has fallen through, the word in the output register is consumed on a rising `rdClk` edge only when `outReady`, `rdEn1`, `rdEn2` and `oe` are all high. Words leave in the order they were stored.
- R3: When the buffer is empty, a word stored on a `wrClk` edge appears on `dOut` with `outReady` high right after the third rising `rdClk` edge that follows that write. The read enables have no effect on this. After the first and second of those edges, `outReady` is still low.
- R4: While `oe` is low, `dOut` is all zeros, and `outReady` and `outDrive` are low. A read attempted then is ignored, so the held word is still there when `oe` returns high.
- R5: After `rstN` falls, `inReady` stays high through the first rising `wrClk` edge and goes low on the second. After `rstN` rises, `inReady` is low after the first rising `wrClk` edge and high after the second.
- R6: `inReady` is low once 1024 words are held, counting the word in the output register. After the first read from a full buffer, `inReady` is still low after the first rising `wrClk` edge and high after the second.
- R7: After `rstN` falls, `outReady` goes low on the third rising `rdClk` edge. When the last held word is consumed, `outReady` goes low on that same `rdClk` edge.
- R8: `halfFull` is high when 513 or more words are held and low at 512 or fewer.
- R9: With the default margin of 128, `almostFlag` is high when the stored count is at most 128 or at least 896, and low in between.
- R10: A falling edge on `defOfs` captures `dIn[8:0]` as margin X. A reset given while `defOfs` is low makes `almostFlag` use X, so that it is high for a count of at most X or at least 1024 − X. The margin does not change outside reset.
- R11: While the synchronized reset is in effect, `dOut` is zero and `outReady`, `inReady`, `halfFull` and `almostFlag` are low. After reset the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write clock, free running |
| rdClk | input | 1 | Read clock, free running, unrelated to wrClk |
| rstN | input | 1 | Active-low reset, asynchronous to both clocks |
| wrEn1 | input | 1 | First write enable |
| wrEn2 | input | 1 | Second write enable |
| dIn | input | 18 | Write data; bits 8:0 also carry the margin value |
| defOfs | input | 1 | Margin define strobe; a falling edge captures dIn[8:0] |
| rdEn1 | input | 1 | First read enable |
| rdEn2 | input | 1 | Second read enable |
| oe | input | 1 | Output enable; gates dOut and outReady |
| dOut | output | 18 | Registered read data, zero while oe is low |
| outDrive | output | 1 | High when the outputs should be driven |
| inReady | output | 1 | High when a write can be accepted |
| outReady | output | 1 | High when dOut holds a valid word |
| halfFull | output | 1 | High at 513 or more held words |
| almostFlag | output | 1 | High within X words of empty or of full |

## Verification
Each result is due a fixed number of edges after its stimulus. Write-side flags settle right after the write edge that changes the count. A read seen by the write side needs two write edges, and so does reset release. The first word needs three read edges after its write, and reset needs three read edges to pull `outReady` low. The bench therefore counts edges from the exact edge of each stimulus and samples half a nanosecond after the edge in question. Inputs change on falling edges. The scoreboard monitor samples one nanosecond after the read-clock falling edge, so the word it compares is the one the next rising edge will consume. The two clock periods are chosen so that their rising edges never coincide. This makes the edge counting unambiguous.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  // strobes from the pointer/flag control to the storage datapath
  typedef struct packed {
    logic memWr;    // store wrData at wrAddr on this write edge
    logic outLoad;  // move mem[rdAddr] into the output register
    logic outClr;   // read-domain reset: clear the output register
  } dcf_strobe_t;
endpackage

// File: rtl/dcf_ctrl.sv
`timescale 1ns/1ps
module dcf_ctrl #(
  parameter int AW      = 10,
  parameter int OW      = 9,
  parameter int DEF_OFS = 128,
  parameter int W_STG   = 2,
  parameter int R_STG   = 3
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  logic                 rstN,
  input  logic                 wrEn1,
  input  logic                 wrEn2,
  input  logic                 rdEn1,
  input  logic                 rdEn2,
  input  logic                 oe,
  input  logic                 defOfs,
  input  logic [OW-1:0]        ofsIn,
  output dcf_pkg::dcf_strobe_t stb,
  output logic [AW-1:0]        wrAddr,
  output logic [AW-1:0]        rdAddr,
  output logic                 inReady,
  output logic                 outReady,
  output logic                 halfFull,
  output logic                 almostFlag
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_UP = PW'(DEPTH / 2 + 1);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [W_STG-1:0] wRstPipe;
  logic             wRun;
  logic [PW-1:0]    wptrBin, wptrGray, rGrayS1, rGrayS2, wrCount;
  logic             wrFull, wrAccept, defQ;
  logic [OW-1:0]    ofsPend, ofsActive;

  always_ff @(posedge wrClk) wRstPipe <= {wRstPipe[W_STG-2:0], rstN};
  assign wRun = wRstPipe[W_STG-1];

  assign wrCount  = wptrBin - fromGray(rGrayS2);
  assign wrFull   = (wrCount == DEPTH_V);
  assign inReady  = wRun & ~wrFull;
  assign wrAccept = inReady & wrEn1 & wrEn2;

  always_ff @(posedge wrClk) begin
    if (!wRun) begin
      wptrBin  <= '0;
      wptrGray <= '0;
      rGrayS1  <= '0;
      rGrayS2  <= '0;
    end else begin
      rGrayS1 <= rptrGray;
      rGrayS2 <= rGrayS1;
      if (wrAccept) begin
        wptrBin  <= wptrBin + 1'b1;
        wptrGray <= toGray(wptrBin + 1'b1);
      end
    end
  end

  // margin capture on the falling define strobe, applied while in reset
  always_ff @(posedge wrClk) begin
    defQ <= defOfs;
    if (defQ && !defOfs) ofsPend <= ofsIn;
  end

  always_ff @(posedge wrClk) begin
    if (!wRun) ofsActive <= defOfs ? OW'(DEF_OFS) : ofsPend;
  end

  assign halfFull   = wRun & (wrCount >= HALF_UP);
  assign almostFlag = wRun & ((wrCount <= PW'(ofsActive)) |
                              (wrCount >= DEPTH_V - PW'(ofsActive)));

  // ---------------- read domain ----------------
  logic [R_STG-1:0] rRstPipe;
  logic             rRun;
  logic [PW-1:0]    fetchBin, rptrBin, rptrGray, wGrayS1, wGrayS2;
  logic             orFlag, rdAccept, avail, outLoad;

  always_ff @(posedge rdClk) rRstPipe <= {rRstPipe[R_STG-2:0], rstN};
  assign rRun = rRstPipe[R_STG-1];

  assign avail    = (fetchBin != fromGray(wGrayS2));
  assign rdAccept = orFlag & rdEn1 & rdEn2 & oe;
  assign outLoad  = rRun & avail & (~orFlag | rdAccept);

  always_ff @(posedge rdClk) begin
    if (!rRun) begin
      fetchBin <= '0;
      rptrBin  <= '0;
      rptrGray <= '0;
      wGrayS1  <= '0;
      wGrayS2  <= '0;
      orFlag   <= 1'b0;
    end else begin
      wGrayS1 <= wptrGray;
      wGrayS2 <= wGrayS1;
      if (rdAccept) begin
        rptrBin  <= rptrBin + 1'b1;
        rptrGray <= toGray(rptrBin + 1'b1);
      end
      if (outLoad) begin
        fetchBin <= fetchBin + 1'b1;
        orFlag   <= 1'b1;
      end else if (rdAccept) begin
        orFlag <= 1'b0;
      end
    end
  end

  assign outReady    = rRun & orFlag & oe;
  assign stb.memWr   = wrAccept;
  assign stb.outLoad = outLoad;
  assign stb.outClr  = ~rRun;
  assign wrAddr      = wptrBin[AW-1:0];
  assign rdAddr      = fetchBin[AW-1:0];
endmodule

// File: rtl/dcf_datapath.sv
`timescale 1ns/1ps
module dcf_datapath #(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  dcf_pkg::dcf_strobe_t stb,
  input  logic [AW-1:0]        wrAddr,
  input  logic [AW-1:0]        rdAddr,
  input  logic [DW-1:0]        wrData,
  input  logic                 oe,
  output logic [DW-1:0]        dOut,
  output logic                 outDrive
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (stb.memWr) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (stb.outClr)       outReg <= '0;
    else if (stb.outLoad) outReg <= mem[rdAddr];
  end

  assign dOut     = oe ? outReg : '0;
  assign outDrive = oe;
endmodule

// File: rtl/dcf_top.sv
`timescale 1ns/1ps
module dcf_top #(
  parameter int DW      = 18,
  parameter int AW      = 10,
  parameter int OW      = 9,
  parameter int DEF_OFS = 128
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEn1,
  input  logic          wrEn2,
  input  logic [DW-1:0] dIn,
  input  logic          defOfs,
  input  logic          rdEn1,
  input  logic          rdEn2,
  input  logic          oe,
  output logic [DW-1:0] dOut,
  output logic          outDrive,
  output logic          inReady,
  output logic          outReady,
  output logic          halfFull,
  output logic          almostFlag
);
  dcf_pkg::dcf_strobe_t stb;
  logic [AW-1:0] wrAddr, rdAddr;

  dcf_ctrl #(.AW(AW), .OW(OW), .DEF_OFS(DEF_OFS), .W_STG(2), .R_STG(3)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn1(wrEn1), .wrEn2(wrEn2), .rdEn1(rdEn1), .rdEn2(rdEn2), .oe(oe),
    .defOfs(defOfs), .ofsIn(dIn[OW-1:0]),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inReady(inReady), .outReady(outReady),
    .halfFull(halfFull), .almostFlag(almostFlag)
  );

  dcf_datapath #(.AW(AW), .DW(DW)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(dIn), .oe(oe),
    .dOut(dOut), .outDrive(outDrive)
  );
endmodule

// File: rtl/dcf_checker.sv
`timescale 1ns/1ps
module dcf_checker #(
  parameter int AW = 10,
  parameter int DW = 18,
  parameter int OW = 9
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          wRun,
  input logic          rRun,
  input logic          inReady,
  input logic          wrEn1,
  input logic          wrEn2,
  input logic          rdEn1,
  input logic          rdEn2,
  input logic          oe,
  input logic          orFlag,
  input logic [AW:0]   wptrBin,
  input logic [AW:0]   wrCount,
  input logic [OW-1:0] ofsActive,
  input logic [DW-1:0] outReg
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(1 << AW);

  // R1: an accepted write advances the write pointer by exactly one
  p_wr_adv_r1: assert property (@(posedge wrClk) disable iff (!rstN)
    (wRun && inReady && wrEn1 && wrEn2) |=> (wptrBin == $past(wptrBin) + 1'b1));

  // R1: without an accepted write the pointer holds
  p_wr_hold_r1: assert property (@(posedge wrClk) disable iff (!rstN)
    (wRun && !(inReady && wrEn1 && wrEn2)) |=> $stable(wptrBin));

  // R6: the held count never exceeds the depth
  p_no_overflow_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    wRun |-> (wrCount <= DEPTH_V));

  // R2: a valid word not being read stays in the output register
  p_rd_hold_r2: assert property (@(posedge rdClk) disable iff (!rstN)
    (rRun && orFlag && !(rdEn1 && rdEn2 && oe)) |=> $stable(outReg));

  // R10: the margin changes only while reset is in effect
  p_ofs_hold_r10: assert property (@(posedge wrClk) disable iff (!rstN)
    (wRun && $past(wRun)) |-> $stable(ofsActive));
endmodule

bind dcf_top dcf_checker #(.AW(AW), .DW(DW), .OW(OW)) u_dcf_checker (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wRun(u_ctrl.wRun), .rRun(u_ctrl.rRun), .inReady(inReady),
  .wrEn1(wrEn1), .wrEn2(wrEn2), .rdEn1(rdEn1), .rdEn2(rdEn2), .oe(oe),
  .orFlag(u_ctrl.orFlag), .wptrBin(u_ctrl.wptrBin), .wrCount(u_ctrl.wrCount),
  .ofsActive(u_ctrl.ofsActive), .outReg(u_dp.outReg)
);

// File: tb/dcf_top_bench.sv
`timescale 1ns/1ps
module dcf_top_bench;
  localparam int DW = 18;
  localparam int DEPTH = 1024;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic wrEn1 = 1'b0, wrEn2 = 1'b0, defOfs = 1'b1;
  logic rdEn1 = 1'b0, rdEn2 = 1'b0, oe = 1'b1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic outDrive, inReady, outReady, halfFull, almostFlag;

  always #2.5  wrClk = ~wrClk;   // 200 MHz write clock
  always #3.65 rdClk = ~rdClk;   // unrelated read clock, edges never coincide

  dcf_top u_dcf_top (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn1(wrEn1), .wrEn2(wrEn2),
    .dIn(dIn), .defOfs(defOfs), .rdEn1(rdEn1), .rdEn2(rdEn2), .oe(oe),
    .dOut(dOut), .outDrive(outDrive), .inReady(inReady), .outReady(outReady),
    .halfFull(halfFull), .almostFlag(almostFlag)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] expQ[$];
  bit monOn = 1'b0;
  bit wDone = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitor: the word shown now is consumed at the next rdClk rise
  initial forever begin
    @(negedge rdClk);
    #1;
    if (monOn && outReady && rdEn1 && rdEn2 && oe) begin
      if (expQ.size() == 0) check("R2", "unexpected word", int'(dOut), -1);
      else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        check("R2", "data order", int'(dOut), int'(e));
      end
    end
  end

  // driver: one write attempt on the next wrClk rise
  task automatic drvWrite(input logic [DW-1:0] v, input bit e1, input bit e2);
    @(negedge wrClk);
    dIn = v; wrEn1 = e1; wrEn2 = e2;
    if (inReady && e1 && e2) expQ.push_back(v);
    @(posedge wrClk);
    #0.5;
  endtask

  task automatic wrIdle();
    @(negedge wrClk);
    wrEn1 = 1'b0; wrEn2 = 1'b0;
  endtask

  task automatic rdWait(input int n);
    for (int i = 0; i < n; i++) @(posedge rdClk);
    #0.5;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // ---- reset state (R11) and release timing (R5) ----
    repeat (20) @(negedge wrClk);
    check("R11", "dOut in reset", int'(dOut), 0);
    check("R11", "outReady in reset", int'(outReady), 0);
    check("R11", "inReady in reset", int'(inReady), 0);
    check("R11", "halfFull in reset", int'(halfFull), 0);
    check("R11", "almostFlag in reset", int'(almostFlag), 0);
    rstN = 1'b1;
    @(posedge wrClk); #0.5;
    check("R5", "inReady 1st edge after release", int'(inReady), 0);
    @(posedge wrClk); #0.5;
    check("R5", "inReady 2nd edge after release", int'(inReady), 1);
    rdWait(8);
    check("R9", "almostFlag empty default margin", int'(almostFlag), 1);
    check("R11", "empty after reset", int'(outReady), 0);

    // ---- fall-through latency, read enables high (R3), last-word drop (R7) ----
    rdEn1 = 1'b1; rdEn2 = 1'b1;
    drvWrite(18'h2A5A5, 1'b1, 1'b1);
    wrEn1 = 1'b0; wrEn2 = 1'b0;
    expQ.delete();
    rdWait(1);
    check("R3", "outReady after 1st rd edge", int'(outReady), 0);
    rdWait(1);
    check("R3", "outReady after 2nd rd edge", int'(outReady), 0);
    rdWait(1);
    check("R3", "outReady after 3rd rd edge", int'(outReady), 1);
    check("R3", "dOut after 3rd rd edge", int'(dOut), 'h2A5A5);
    rdWait(1);
    check("R7", "outReady after last word read", int'(outReady), 0);
    @(negedge rdClk); rdEn1 = 1'b0; rdEn2 = 1'b0;

    // ---- a write with one enable low stores nothing (R1) ----
    drvWrite(18'h00111, 1'b1, 1'b0);
    wrIdle();
    rdWait(6);
    check("R1", "outReady after gated write", int'(outReady), 0);

    // ---- output enable gating (R4) ----
    drvWrite(18'h15555, 1'b1, 1'b1);
    wrIdle();
    expQ.delete();
    rdWait(6);
    check("R3", "word fell through", int'(dOut), 'h15555);
    @(negedge rdClk); oe = 1'b0; rdEn1 = 1'b1; rdEn2 = 1'b1;
    rdWait(3);
    check("R4", "dOut with oe low", int'(dOut), 0);
    check("R4", "outReady with oe low", int'(outReady), 0);
    check("R4", "outDrive with oe low", int'(outDrive), 0);
    @(negedge rdClk); oe = 1'b1; rdEn1 = 1'b0; rdEn2 = 1'b0;
    #1;
    check("R4", "word kept after ignored read", int'(dOut), 'h15555);
    check("R4", "outReady back with oe", int'(outReady), 1);
    @(negedge rdClk); rdEn1 = 1'b1; rdEn2 = 1'b1;
    @(negedge rdClk); rdEn1 = 1'b0; rdEn2 = 1'b0;
    #1;
    check("R7", "outReady after consuming only word", int'(outReady), 0);

    // ---- streaming with gapped enables on both sides (R1, R2) ----
    monOn = 1'b1;
    wDone = 1'b0;
    fork
      begin
        for (int i = 0; i < 400; i++)
          drvWrite(DW'(i * 37 + 5), (i % 5) != 3, (i % 7) != 2);
        wrIdle();
        wDone = 1'b1;
      end
      begin
        while (!(wDone && expQ.size() == 0)) begin
          @(negedge rdClk);
          rdEn1 = ($urandom % 4) != 0;
          rdEn2 = ($urandom % 3) != 0;
        end
        @(negedge rdClk); rdEn1 = 1'b0; rdEn2 = 1'b0;
      end
    join
    rdWait(4);
    check("R2", "stream drained", expQ.size(), 0);
    check("R2", "outReady after stream", int'(outReady), 0);

    // ---- fill to full: half-full, default margin, full (R6, R8, R9) ----
    for (int n = 1; n <= DEPTH; n++) begin
      drvWrite(DW'(n), 1'b1, 1'b1);
      if (n == 128) check("R9", "almostFlag at 128", int'(almostFlag), 1);
      if (n == 129) check("R9", "almostFlag at 129", int'(almostFlag), 0);
      if (n == 512) check("R8", "halfFull at 512", int'(halfFull), 0);
      if (n == 513) check("R8", "halfFull at 513", int'(halfFull), 1);
      if (n == 895) check("R9", "almostFlag at 895", int'(almostFlag), 0);
      if (n == 896) check("R9", "almostFlag at 896", int'(almostFlag), 1);
    end
    check("R6", "inReady when full", int'(inReady), 0);
    drvWrite(18'h3FFFF, 1'b1, 1'b1);
    wrIdle();
    check("R6", "inReady after blocked write", int'(inReady), 0);
    check("R6", "words queued", expQ.size(), DEPTH);
    @(negedge rdClk); rdEn1 = 1'b1; rdEn2 = 1'b1;
    @(posedge rdClk);
    fork
      begin
        @(negedge rdClk); rdEn1 = 1'b0; rdEn2 = 1'b0;
      end
      begin
        @(posedge wrClk); #0.5;
        check("R6", "inReady 1st wr edge after read", int'(inReady), 0);
        @(posedge wrClk); #0.5;
        check("R6", "inReady 2nd wr edge after read", int'(inReady), 1);
      end
    join
    @(negedge rdClk); rdEn1 = 1'b1; rdEn2 = 1'b1;
    while (expQ.size() != 0) @(negedge rdClk);
    @(negedge rdClk); rdEn1 = 1'b0; rdEn2 = 1'b0;
    rdWait(4);
    check("R7", "outReady after drain", int'(outReady), 0);
    monOn = 1'b0;

    // ---- reset entry timing on both sides (R5, R7) ----
    drvWrite(18'h0ABCD, 1'b1, 1'b1);
    wrIdle();
    rdWait(6);
    check("R3", "word ready before reset", int'(outReady), 1);
    @(negedge wrClk);
    dIn = 18'd40;
    defOfs = 1'b0;
    repeat (3) @(negedge wrClk);
    rstN = 1'b0;
    fork
      begin
        @(posedge wrClk); #0.5;
        check("R5", "inReady 1st wr edge in reset", int'(inReady), 1);
        @(posedge wrClk); #0.5;
        check("R5", "inReady 2nd wr edge in reset", int'(inReady), 0);
      end
      begin
        @(posedge rdClk); #0.5;
        check("R7", "outReady 1st rd edge in reset", int'(outReady), 1);
        @(posedge rdClk); #0.5;
        check("R7", "outReady 2nd rd edge in reset", int'(outReady), 1);
        @(posedge rdClk); #0.5;
        check("R7", "outReady 3rd rd edge in reset", int'(outReady), 0);
      end
    join
    rdWait(6);
    check("R11", "output register cleared", int'(dOut), 0);

    // ---- programmed margin X = 40 (R10) ----
    @(negedge wrClk); rstN = 1'b1;
    rdWait(8);
    check("R10", "almostFlag empty with X=40", int'(almostFlag), 1);
    for (int n = 1; n <= 41; n++) begin
      drvWrite(DW'(n + 'h100), 1'b1, 1'b1);
      if (n == 40) check("R10", "almostFlag at 40", int'(almostFlag), 1);
      if (n == 41) check("R10", "almostFlag at 41", int'(almostFlag), 0);
    end
    wrIdle();
    expQ.delete();
    defOfs = 1'b1;
    repeat (4) @(negedge wrClk);
    check("R10", "margin kept after define rises", int'(almostFlag), 0);

    finishRun();
  end
endmodule